// File: doc/BRIEF.md
# Eight-Bit Bidirectional I/O Port

This block is an eight-bit general-purpose I/O port with three registers on a small register bus. A direction register picks, one pin at a time, whether the pin is driven or left floating. An output latch holds the value that is driven on pins set to output. A pin register returns the levels seen on the pads after a two-stage synchroniser.

Software can write the latch through either the latch address or the pin address. A read of the latch address returns what was written, whatever the pads show. A read-modify-write through the latch address therefore keeps bits that a loaded pin would otherwise corrupt.

There are two reset inputs. The power-on/brown-out reset loads the latch with a parameter value, which stands in for its undefined power-up contents. The other reset, used for external or watchdog resets, returns the direction register to all inputs and leaves the latch untouched. Bit positions outside a parameter mask are unimplemented.

The bus is a plain register interface with no handshake. A write completes at the clock edge where `bus_we` is high. Read data is combinational from `bus_addr`. Pads are modelled as an enable and data pair, where a low enable means high impedance.

Top module: `gpio_port8`

## Requirements
- R1: Both reset inputs (`por_n`, `rst_n`, active low, sampled at the clock edge) set every implemented direction bit to 1 (input). The direction register is read at address 0.
- R2: A direction bit of 0 makes `pad_oe` high for that pin and drives `pad_out` with the latch bit. A direction bit of 1 gives `pad_oe` low and `pad_out` low.
- R3: A write to address 1 (latch) or to address 2 (pin) updates the latch at that clock edge. A read of address 1 returns the latch.
- R4: A read of address 2 returns `pad_in` as it stood two clock edges earlier, masked to the implemented bits. Both resets clear the synchroniser.
- R5: `por_n` low loads the latch with `LAT_POR_VAL` masked to the implemented bits. `por_n` takes priority over `rst_n`.
- R6: `rst_n` low with `por_n` high keeps the latch value. Bus writes made while either reset is low are ignored.
- R7: Bits outside `IMPL_MASK` read as 0 at every address, ignore writes, and never drive (`pad_oe` and `pad_out` are 0).
- R8: Address 3 reads as 0, and writes to it change no register.
- R9: When the pads differ from the latch, a read of address 1 still returns the latch. A read-modify-write through address 1 changes only the modified bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on/brown-out reset, active low, synchronous |
| rst_n | input | 1 | Other reset (external, watchdog), active low, synchronous |
| bus_addr | input | 2 | Register select: 0 direction, 1 latch, 2 pin, 3 none |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pad_in | input | 8 | Pad levels seen from outside |
| pad_out | output | 8 | Value driven on the pads |
| pad_oe | output | 8 | Pad drive enable, low means high impedance |

## Verification
The bench is built with bit 7 unimplemented and a non-zero power-up latch value. This lets it separate masked bits and the parameterised reset value from ordinary zeros.

Pad levels of 55h, AAh and FFh are presented while the pin address is read. These patterns separate a correct two-cycle synchroniser from one that is one cycle short or long. Pads held opposite to the latch separate the latch read path from the pin read path.

A warm reset and a power-on reset are each pulsed after the latch is loaded, which tells the two reset behaviours apart. Writes to address 3 and to the masked bit show that nothing is stored from them.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    SEL_DIR  = 2'd0,
    SEL_LAT  = 2'd1,
    SEL_PIN  = 2'd2,
    SEL_NONE = 2'd3
  } gpio_sel_e;
endpackage

// File: rtl/gpio_dir_reg.sv
module gpio_dir_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] IMPL_MASK = '1
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dir_q
);
  always_ff @(posedge clk) begin
    if (!por_n || !rst_n) dir_q <= IMPL_MASK;
    else if (wr_en)       dir_q <= wdata & IMPL_MASK;
  end
endmodule

// File: rtl/gpio_latch_reg.sv
module gpio_latch_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] IMPL_MASK = '1,
  parameter logic [W-1:0] LAT_POR_VAL = '0
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] lat_q
);
  localparam logic [W-1:0] PorVal = LAT_POR_VAL & IMPL_MASK;
  always_ff @(posedge clk) begin
    if (!por_n)               lat_q <= PorVal;
    else if (rst_n && wr_en)  lat_q <= wdata & IMPL_MASK;
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!clr_n) stg[i] <= '0;
      else if (i == 0) stg[i] <= d;
      else stg[i] <= stg[(i == 0) ? 0 : i-1];
    end
  end
  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_port8.sv
module gpio_port8 #(
  parameter int W = 8,
  parameter logic [W-1:0] IMPL_MASK = '1,
  parameter logic [W-1:0] LAT_POR_VAL = '0,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         rst_n,
  input  logic [1:0]   bus_addr,
  input  logic         bus_we,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  import gpio_pkg::*;

  gpio_sel_e    sel;
  logic         dir_wr, lat_wr;
  logic [W-1:0] dir_q, lat_q, pin_q;

  assign sel    = gpio_sel_e'(bus_addr);
  assign dir_wr = bus_we && (sel == SEL_DIR);
  assign lat_wr = bus_we && ((sel == SEL_LAT) || (sel == SEL_PIN));

  gpio_dir_reg #(.W(W), .IMPL_MASK(IMPL_MASK)) u_dir (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .wr_en(dir_wr), .wdata(bus_wdata), .dir_q(dir_q)
  );

  gpio_latch_reg #(.W(W), .IMPL_MASK(IMPL_MASK), .LAT_POR_VAL(LAT_POR_VAL)) u_lat (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .wr_en(lat_wr), .wdata(bus_wdata), .lat_q(lat_q)
  );

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .clr_n(por_n && rst_n), .d(pad_in), .q(pin_q)
  );

  assign pad_oe  = ~dir_q & IMPL_MASK;
  assign pad_out = lat_q & pad_oe;

  always_comb begin
    unique case (sel)
      SEL_DIR:  bus_rdata = dir_q & IMPL_MASK;
      SEL_LAT:  bus_rdata = lat_q & IMPL_MASK;
      SEL_PIN:  bus_rdata = pin_q & IMPL_MASK;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port8_chk.sv
module gpio_port8_chk #(
  parameter int W = 8,
  parameter logic [W-1:0] IMPL_MASK = '1,
  parameter logic [W-1:0] LAT_POR_VAL = '0
) (
  input logic         clk,
  input logic         por_n,
  input logic         rst_n,
  input logic [1:0]   bus_addr,
  input logic         bus_we,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] bus_rdata,
  input logic [W-1:0] pad_in,
  input logic [W-1:0] pad_out,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] lat_q
);
  logic [1:0] since;
  always_ff @(posedge clk) begin
    if (!por_n || !rst_n) since <= '0;
    else if (since != 2'd3) since <= since + 2'd1;
  end

  p_dir_reset_r1: assert property (@(posedge clk)
    (!por_n || !rst_n) |=> (dir_q == IMPL_MASK));

  p_oe_follow_r2: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (bus_we && bus_addr == 2'd0) |=> (pad_oe == (~$past(bus_wdata) & IMPL_MASK)));

  p_lat_write_r3: assert property (@(posedge clk) disable iff (!por_n)
    (rst_n && bus_we && (bus_addr == 2'd1 || bus_addr == 2'd2))
      |=> (lat_q == ($past(bus_wdata) & IMPL_MASK)));

  p_pin_delay_r4: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (since >= 2'd2 && bus_addr == 2'd2) |-> (bus_rdata == ($past(pad_in, 2) & IMPL_MASK)));

  p_por_latch_r5: assert property (@(posedge clk)
    !por_n |=> (lat_q == (LAT_POR_VAL & IMPL_MASK)));

  p_warm_keep_r6: assert property (@(posedge clk) disable iff (!por_n)
    !rst_n |=> $stable(lat_q));

  p_unimpl_zero_r7: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    ((bus_rdata & ~IMPL_MASK) == '0) && ((pad_oe & ~IMPL_MASK) == '0));

  p_addr3_zero_r8: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (bus_addr == 2'd3) |-> (bus_rdata == '0));
endmodule

bind gpio_port8 gpio_port8_chk #(.W(W), .IMPL_MASK(IMPL_MASK), .LAT_POR_VAL(LAT_POR_VAL)) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
  .pad_oe(pad_oe), .dir_q(dir_q), .lat_q(lat_q)
);

// File: tb/gpio_port8_test.sv
`timescale 1ns/1ps
module gpio_port8_test;
  localparam logic [7:0] MASK = 8'h7F;
  localparam logic [7:0] PORV = 8'h12;

  logic       clk = 1'b0;
  logic       por_n = 1'b0, rst_n = 1'b1;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00, pad_in = 8'h00;
  logic [7:0] bus_rdata, pad_out, pad_oe;

  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_port8 #(.W(8), .IMPL_MASK(MASK), .LAT_POR_VAL(PORV)) uut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // Behavioural reference model
  logic [7:0] m_dir = 8'hxx, m_lat = 8'hxx;
  logic [7:0] hist[$] = '{8'h00, 8'h00};
  bit         m_valid = 0;

  always @(posedge clk) begin
    if (!por_n) begin
      m_dir <= MASK; m_lat <= PORV & MASK; m_valid <= 1;
    end else if (!rst_n) begin
      m_dir <= MASK;
    end else begin
      if (bus_we && bus_addr == 2'd0) m_dir <= bus_wdata & MASK;
      if (bus_we && (bus_addr == 2'd1 || bus_addr == 2'd2)) m_lat <= bus_wdata & MASK;
    end
    if (!por_n || !rst_n) hist = '{8'h00, 8'h00};
    else begin
      hist.push_front(pad_in);
      void'(hist.pop_back());
    end
  end

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_dir;
      2'd1: return m_lat;
      2'd2: return hist[1] & MASK;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (m_valid && por_n && !done) begin
      case (bus_addr)
        2'd0: chk("R1 dir read", bus_rdata, exp_rd(bus_addr));
        2'd1: chk("R3 latch read", bus_rdata, exp_rd(bus_addr));
        2'd2: chk("R4 pin read", bus_rdata, exp_rd(bus_addr));
        default: chk("R8 addr3 read", bus_rdata, exp_rd(bus_addr));
      endcase
      chk("R2 pad_oe", pad_oe, ~m_dir & MASK);
      chk("R2 pad_out", pad_out, m_lat & ~m_dir & MASK);
    end
  end

  task automatic step(input logic we, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    bus_we = we; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rd_now(input string req, input logic [1:0] a, input logic [7:0] exp);
    @(negedge clk); #1;
    bus_we = 1'b0; bus_addr = a;
    #1 chk(req, bus_rdata, exp);
  endtask

  logic [7:0] tmp;

  initial begin
    repeat (2) @(posedge clk);
    step(0, 2'd0, 8'h00); por_n = 1'b1;
    rd_now("R1 dir after por", 2'd0, MASK);
    rd_now("R5 latch after por", 2'd1, PORV & MASK);
    chk("R2 no drive after reset", pad_oe, 8'h00);

    step(1, 2'd1, 8'hA5);
    rd_now("R3 R7 latch write via addr1", 2'd1, 8'h25);
    step(1, 2'd0, 8'hF0);
    rd_now("R7 dir masked", 2'd0, 8'h70);
    chk("R2 oe from dir", pad_oe, 8'h0F);
    chk("R2 out from latch", pad_out, 8'h05);
    step(1, 2'd2, 8'h3C);
    rd_now("R3 latch write via addr2", 2'd1, 8'h3C);
    chk("R2 out after latch write", pad_out, 8'h0C);

    // Pin patterns with two-cycle latency
    foreach (tmp[i]) begin end
    step(0, 2'd2, 8'h00); pad_in = 8'h55;
    step(0, 2'd2, 8'h00);
    #1 chk("R4 one edge not yet visible", bus_rdata, 8'h00);
    step(0, 2'd2, 8'h00);
    #1 chk("R4 visible after two edges", bus_rdata, 8'h55);
    pad_in = 8'hAA;
    step(0, 2'd2, 8'h00); step(0, 2'd2, 8'h00);
    #1 chk("R4 pattern AA", bus_rdata, 8'h2A);
    pad_in = 8'hFF;
    step(0, 2'd2, 8'h00); step(0, 2'd2, 8'h00);
    #1 chk("R7 R4 masked FF", bus_rdata, 8'h7F);

    // Read-modify-write with pads opposite to latch
    pad_in = 8'h00;
    step(0, 2'd2, 8'h00); step(0, 2'd2, 8'h00); step(0, 2'd2, 8'h00);
    rd_now("R9 latch read ignores pads", 2'd1, 8'h3C);
    tmp = bus_rdata | 8'h01;
    step(1, 2'd1, tmp);
    rd_now("R9 rmw keeps other bits", 2'd1, 8'h3D);

    // Address 3 and masked bit
    step(1, 2'd3, 8'hFF);
    rd_now("R8 addr3 reads zero", 2'd3, 8'h00);
    rd_now("R8 latch untouched", 2'd1, 8'h3D);
    rd_now("R8 dir untouched", 2'd0, 8'h70);
    step(1, 2'd0, 8'h80);
    rd_now("R7 masked dir bit ignored", 2'd0, 8'h00);
    chk("R7 masked pin never driven", pad_oe, 8'h7F);

    // Warm reset, with a write attempt during it
    step(1, 2'd1, 8'h11); rst_n = 1'b0;
    step(0, 2'd1, 8'h00); rst_n = 1'b1;
    rd_now("R6 latch kept over warm reset", 2'd1, 8'h3D);
    rd_now("R1 dir after warm reset", 2'd0, MASK);

    // Power-on reset with warm reset also low
    step(0, 2'd1, 8'h00); por_n = 1'b0; rst_n = 1'b0;
    step(0, 2'd1, 8'h00); por_n = 1'b1; rst_n = 1'b1;
    rd_now("R5 latch reloaded by por", 2'd1, PORV & MASK);
    rd_now("R1 dir after por", 2'd0, MASK);

    repeat (3) step(0, 2'd2, 8'h00);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule